// File: doc/BRIEF.md
# Delta-Panel Horizontal Start Pulse Generator

This block places the two horizontal start pulses that a delta-arranged LCD panel needs at the start of every line. The first pulse, `hst_r`, serves a panel scanned left to right. The second, `hst_l`, serves a panel scanned right to left. The block runs on a clock at twice the dot rate, so every position is counted in half-dot ticks and the half-dot offsets of the delta layout are exact.

A one-cycle `sync_end` strobe marks the end of horizontal sync and starts each line. At that strobe the block captures four inputs for the whole line: the 4-bit position code, the panel-type select, the scan direction and the new line parity. Both pulses are placed from those captured values. On odd lines the two pulses move by 1.5 dots in opposite directions. Reverse scan exchanges which lines get the shifted positions. The block has no data stream, so every pin is a plain control or status signal.

Top module: `delta_hstart_gen`

## Requirements
- R1: After reset `hst_r`, `hst_l` and `line_odd` are low, and neither pulse appears until the first `sync_end`.
- R2: With `panel_sel`=0, `scan_normal`=1 and an even line, `hst_r` rises 2*(72-2*v) clock cycles after the edge that samples `sync_end`. Here v is the unsigned value of `pos_code`, with bit 3 as MSB. Code 0 gives the latest start and code 15 the earliest.
- R3: With `panel_sel`=1, the same placement holds with a base of 91 dots in place of 72.
- R4: On a line that takes the unshifted positions, `hst_l` rises 5 clock cycles (2.5 dots) after `hst_r`.
- R5: On an odd line in normal scan, `hst_r` is 3 cycles later and `hst_l` is 3 cycles earlier than their unshifted positions.
- R6: With `scan_normal`=0, even lines take the shifted positions of R5 and odd lines take the unshifted positions.
- R7: `line_odd` toggles at each `sync_end`. If `line_rst` is high at that same edge, `line_odd` becomes 0 (even) instead. Between strobes `line_odd` holds its value.
- R8: `pos_code`, `panel_sel` and `scan_normal` are sampled only at `sync_end`. Changing them during a line does not move or alter that line's pulses.
- R9: Each pulse is high for exactly 2 cycles (one dot) and appears exactly once per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the dot rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_end | input | 1 | One-cycle strobe at the end of horizontal sync |
| line_rst | input | 1 | Vertical reference; when high at `sync_end` the new line is even |
| pos_code | input | 4 | Start position code (0 = latest, 15 = earliest) |
| panel_sel | input | 1 | Panel type: 0 = 537-dot, 1 = 827-dot |
| scan_normal | input | 1 | 1 = normal scan, 0 = reverse scan |
| hst_r | output | 1 | Start pulse for the right-scan panel, active high |
| hst_l | output | 1 | Start pulse for the left-scan panel, active high |
| line_odd | output | 1 | Parity of the current line (1 = odd) |

## Verification
The hardest condition to reach is a configuration that changes in the middle of a line. A design that recomputes positions from the live pins would still be correct whenever the pins are steady. To expose it, the bench scrambles the position code, the panel type and the direction one cycle after every strobe. Each line's pulses must then still match the values that were present at the strobe. The sweep covers every code, both panel types and both directions, on both an even and an odd line.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef struct packed {
    logic [3:0] code;
    logic       panel;
    logic       shift;   // line takes the 1.5-dot shifted positions
  } line_cfg_t;
endpackage

// File: rtl/dhs_line_track.sv
module dhs_line_track
  import dhs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_end,
  input  logic      line_rst,
  input  logic [3:0] pos_code,
  input  logic      panel_sel,
  input  logic      scan_normal,
  output logic      line_odd,
  output line_cfg_t cfg
);
  logic par_next;
  assign par_next = line_rst ? 1'b0 : ~line_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_odd <= 1'b0;
      cfg      <= '0;
    end else if (sync_end) begin
      line_odd  <= par_next;
      cfg.code  <= pos_code;
      cfg.panel <= panel_sel;
      cfg.shift <= par_next ^ ~scan_normal;
    end
  end

  p_parity_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_end && !line_rst |=> line_odd != $past(line_odd));
  p_parity_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_end && line_rst |=> !line_odd);
  p_parity_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_end |=> $stable(line_odd));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_end |=> $stable(cfg));
endmodule

// File: rtl/dhs_pos_calc.sv
module dhs_pos_calc
  import dhs_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int BASE_A     = 72,  // dots, panel type 0, code 0
  parameter int BASE_B     = 91,  // dots, panel type 1, code 0
  parameter int STEP_DOTS  = 2,
  parameter int LAG_HALF   = 5,   // second pulse lag, half-dots
  parameter int SHIFT_HALF = 3    // odd-line shift, half-dots
) (
  input  line_cfg_t            cfg,
  output logic [1:0][CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] B2A   = CNT_W'(2 * BASE_A);
  localparam logic [CNT_W-1:0] B2B   = CNT_W'(2 * BASE_B);
  localparam logic [CNT_W-1:0] STEPH = CNT_W'(2 * STEP_DOTS);
  localparam logic [CNT_W-1:0] LAG   = CNT_W'(LAG_HALF);
  localparam logic [CNT_W-1:0] SHF   = CNT_W'(SHIFT_HALF);

  logic [CNT_W-1:0] base_r, base_l;
  always_comb begin
    base_r = (cfg.panel ? B2B : B2A) - CNT_W'(cfg.code) * STEPH;
    base_l = base_r + LAG;
    pos[0] = cfg.shift ? base_r + SHF : base_r;
    pos[1] = cfg.shift ? base_l - SHF : base_l;
  end
endmodule

// File: rtl/dhs_pulse_timer.sv
module dhs_pulse_timer #(
  parameter int CNT_W = 9,
  parameter int NOUT  = 2,
  parameter int PW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic [NOUT-1:0][CNT_W-1:0] pos,
  output logic [NOUT-1:0]          pulse
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] PWW  = CNT_W'(PW);

  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CMAX;
    else if (restart)     cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign pulse[i] = (cnt != CMAX) && (cnt >= pos[i]) && (cnt < pos[i] + PWW);

    p_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[i]) && !restart |=> pulse[i]);
    p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] && $past(pulse[i]) && !restart |=> !pulse[i]);
  end
endmodule

// File: rtl/delta_hstart_gen.sv
module delta_hstart_gen
  import dhs_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_end,
  input  logic       line_rst,
  input  logic [3:0] pos_code,
  input  logic       panel_sel,
  input  logic       scan_normal,
  output logic       hst_r,
  output logic       hst_l,
  output logic       line_odd
);
  line_cfg_t              cfg;
  logic [1:0][CNT_W-1:0] pos;
  logic [1:0]            pulses;

  dhs_line_track u_track (
    .clk(clk), .rst_n(rst_n), .sync_end(sync_end), .line_rst(line_rst),
    .pos_code(pos_code), .panel_sel(panel_sel), .scan_normal(scan_normal),
    .line_odd(line_odd), .cfg(cfg)
  );

  dhs_pos_calc #(.CNT_W(CNT_W)) u_pos (.cfg(cfg), .pos(pos));

  dhs_pulse_timer #(.CNT_W(CNT_W), .NOUT(2), .PW(2)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(sync_end), .pos(pos), .pulse(pulses)
  );

  assign hst_r = pulses[0];
  assign hst_l = pulses[1];

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hst_r) |-> !$past(sync_end));
endmodule

// File: tb/tb_delta_hstart_gen.sv
module tb_delta_hstart_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LINE_LEN   = 220;

  logic clk = 0, rst_n = 0, sync_end = 0, line_rst = 0;
  logic [3:0] pos_code = 0;
  logic panel_sel = 0, scan_normal = 1;
  logic hst_r, hst_l, line_odd;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delta_hstart_gen dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_line(input bit rst_line, input int code, input bit pan, input bit nrm);
    int first_r = -1, first_l = -1, cnt_r = 0, cnt_l = 0;
    int e1, er, el, exp_par;
    bit shift;
    @(negedge clk);
    sync_end = 1; line_rst = rst_line;
    pos_code = 4'(code); panel_sel = pan; scan_normal = nrm;
    exp_par = rst_line ? 0 : !line_odd;
    @(posedge clk);
    @(negedge clk);
    sync_end = 0; line_rst = 0;
    // R8: scramble configuration for the remainder of the line
    pos_code = 4'(code ^ 5); panel_sel = !pan; scan_normal = !nrm;
    check(line_odd == exp_par, "R7 parity", line_odd, exp_par);
    for (int k = 0; k < LINE_LEN; k++) begin
      if (hst_r) begin if (first_r < 0) first_r = k; cnt_r++; end
      if (hst_l) begin if (first_l < 0) first_l = k; cnt_l++; end
      @(negedge clk);
    end
    shift = exp_par[0] ^ !nrm;
    e1 = 2 * ((pan ? 91 : 72) - 2 * code);
    er = e1 + (shift ? 3 : 0);
    el = e1 + 5 - (shift ? 3 : 0);
    check(first_r == er, shift ? (nrm ? "R5 hst_r odd" : "R6 hst_r rev")
                               : (pan ? "R3 hst_r" : "R2 hst_r"), first_r, er);
    check(first_l == el, shift ? (nrm ? "R5 hst_l odd" : "R6 hst_l rev")
                               : "R4 hst_l lag", first_l, el);
    check(cnt_r == 2, "R9 hst_r width", cnt_r, 2);
    check(cnt_l == 2, "R9 hst_l width", cnt_l, 2);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check(!hst_r && !hst_l && !line_odd, "R1 reset", {hst_r, hst_l, line_odd}, 0);
    rst_n = 1;
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (hst_r || hst_l || line_odd) seen++;
    end
    check(seen == 0, "R1 idle", seen, 0);
    for (int pan = 0; pan < 2; pan++)
      for (int nrm = 0; nrm < 2; nrm++)
        for (int code = 0; code < 16; code++) begin
          run_line(1'b1, code, pan[0], nrm[0]);  // even line
          run_line(1'b0, code, pan[0], nrm[0]);  // odd line
        end
    // R7: parity keeps toggling over several lines without vertical reference
    run_line(1'b0, 1, 1'b0, 1'b1);
    run_line(1'b0, 15, 1'b1, 1'b1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule